// File: doc/BRIEF.md
# Asynchronous SRAM Port Access Controller

This block lets a clocked host read and write one port of an asynchronous static RAM organised as 4096 bytes. The host side is a request/ready handshake. A request carries a 12-bit address, a write byte and a write flag. A read returns its byte with a one-cycle valid pulse. The memory side drives the address and three active-low strobes: chip enable, read/write and output enable. The 8-bit bidirectional data bus is split into a driven byte, a driver enable and a sampled byte, and the pad ring joins them.

The memory has no clock, so every phase of an access is timed by counting system clock cycles. The wait counts are parameters, chosen from the system clock period and the memory's speed grade:

- address access time
- chip-enable access time
- output-enable access time
- minimum write pulse

The sequence follows the memory's asynchronous rules:

- The address only moves while the part is deselected.
- A write is the overlap of chip enable and read/write, both low, with output enable held high so the short pulse rule applies.
- The write byte is held one cycle past the end of the strobe.
- Read data is sampled only after the slowest of the three access paths has elapsed.

Reset `rst_n` is asynchronous active-low and is expected to be released synchronously to `clk`.

Top module: `asram_port_ctrl`

## Requirements
- R1: While reset is asserted, `ready` is 1, `sram_ce_n`, `sram_we_n` and `sram_oe_n` are 1, and `sram_dq_oe` and `rd_valid` are 0.
- R2: A request is taken on a rising edge where `req` and `ready` are both 1. `ready` is then 0 for exactly RD_WAIT+1 cycles for a read (`req_wr`=0), or T_WP_CYC+2 cycles for a write (`req_wr`=1).
- R3: `sram_addr` takes the accepted address while `sram_ce_n` is still high. It has one full setup cycle before `sram_ce_n` falls, and it does not change while `sram_ce_n` is low.
- R4: On a write, `sram_ce_n` and `sram_we_n` fall in the same cycle and stay low together for exactly T_WP_CYC cycles. `sram_ce_n` never falls before `sram_we_n`.
- R5: `sram_oe_n` stays high for the whole write. `sram_dq_oe` is 1 from the first write-strobe cycle through one cycle after the strobe ends, with `sram_dq_out` holding the accepted byte unchanged. `sram_dq_oe` is never 1 while `sram_oe_n` is low.
- R6: On a read, `sram_ce_n` and `sram_oe_n` are low and `sram_we_n` is high for exactly RD_WAIT = max(T_AA_CYC, T_ACE_CYC, T_AOE_CYC) cycles. `sram_dq_in` is sampled on the last rising edge of that window.
- R7: `rd_valid` is a single-cycle pulse in the cycle after the read strobes rise, with `rd_data` equal to the sampled byte. A write produces no pulse.
- R8: Between two accesses `sram_ce_n` is high for at least two cycles, even when `req` stays high continuously.
- R9: The host fields are sampled only at acceptance. `req` while `ready` is 0, and changes of `req_addr`/`req_wdata` during an access, have no effect on the memory pins or on the data written.
- R10: Every address from 0x000 to 0xFFF is reachable. A read returns the byte most recently written to that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req | input | 1 | Host access request |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Host address |
| req_wdata | input | DATA_W | Host write byte |
| ready | output | 1 | Controller idle; request taken this edge if `req` is 1 |
| rd_valid | output | 1 | One-cycle read-data strobe |
| rd_data | output | DATA_W | Captured read byte |
| sram_addr | output | ADDR_W | Memory address |
| sram_ce_n | output | 1 | Memory chip enable, active low |
| sram_we_n | output | 1 | Memory read/write, low = write |
| sram_oe_n | output | 1 | Memory output enable, active low |
| sram_dq_out | output | DATA_W | Byte to drive onto the data bus |
| sram_dq_oe | output | 1 | Data bus driver enable |
| sram_dq_in | input | DATA_W | Byte sampled from the data bus |

## Verification
The bench's memory model returns a corrupted byte until the read strobes have been low for RD_WAIT cycles. A controller that sampled even one cycle early would therefore return wrong data rather than pass by luck. The model also times every write overlap and checks for several faults:

- a pulse that is short or long
- chip enable falling ahead of read/write
- output enable low during a write
- the data driver released on the strobe's rising edge instead of a cycle later
- an address that moves under an active chip enable

Requests are held high across busy periods, and host fields are scribbled during accesses. A controller that re-sampled fields or accepted while busy would therefore write the wrong byte or address. The same stimulus catches one that skipped the deselect cycle between back-to-back accesses.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SETUP = 3'd1,
    ST_RD    = 3'd2,
    ST_WR    = 3'd3,
    ST_HOLD  = 3'd4
  } asram_state_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/asram_wait_cnt.sv
module asram_wait_cnt #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          done
);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)              cnt_d = load_val;
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/asram_fsm.sv
module asram_fsm
  import asram_pkg::*;
#(
  parameter int CW       = 3,
  parameter int RD_WAIT  = 4,
  parameter int WR_PULSE = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req,
  input  logic         req_wr,
  input  logic         cnt_done,
  output asram_state_e state_q,
  output asram_state_e state_d,
  output logic         accept,
  output logic         ready,
  output logic         cnt_load,
  output logic [CW-1:0] cnt_val
);
  logic is_wr_q, is_wr_d;

  assign ready  = (state_q == ST_IDLE);
  assign accept = ready & req;

  always_comb begin
    state_d  = state_q;
    is_wr_d  = is_wr_q;
    cnt_load = 1'b0;
    cnt_val  = CW'(RD_WAIT - 1);
    unique case (state_q)
      ST_IDLE: begin
        if (req) begin
          state_d = ST_SETUP;
          is_wr_d = req_wr;
        end
      end
      ST_SETUP: begin
        cnt_load = 1'b1;
        if (is_wr_q) begin
          state_d = ST_WR;
          cnt_val = CW'(WR_PULSE - 1);
        end else begin
          state_d = ST_RD;
        end
      end
      ST_RD:   if (cnt_done) state_d = ST_IDLE;
      ST_WR:   if (cnt_done) state_d = ST_HOLD;
      ST_HOLD: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      is_wr_q <= 1'b0;
    end else begin
      state_q <= state_d;
      is_wr_q <= is_wr_d;
    end
  end
endmodule

// File: rtl/asram_pins.sv
module asram_pins
  import asram_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  asram_state_e state_q,
  input  asram_state_e state_d,
  input  logic         accept,
  input  logic         cnt_done,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  input  logic [DW-1:0] dq_in,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] dq_out,
  output logic          dq_oe,
  output logic          ce_n,
  output logic          we_n,
  output logic          oe_n,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid
);
  logic ce_n_d, we_n_d, oe_n_d, dq_oe_d, capture;

  // Strobes are registered from the next state so pins never glitch.
  always_comb begin
    ce_n_d  = !((state_d == ST_RD) || (state_d == ST_WR));
    we_n_d  = !(state_d == ST_WR);
    oe_n_d  = !(state_d == ST_RD);
    dq_oe_d = (state_d == ST_WR) || (state_d == ST_HOLD);
    capture = (state_q == ST_RD) && cnt_done;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_n     <= 1'b1;
      we_n     <= 1'b1;
      oe_n     <= 1'b1;
      dq_oe    <= 1'b0;
      rd_valid <= 1'b0;
    end else begin
      ce_n     <= ce_n_d;
      we_n     <= we_n_d;
      oe_n     <= oe_n_d;
      dq_oe    <= dq_oe_d;
      rd_valid <= capture;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr <= '0;
      dq_out   <= '0;
    end else if (accept) begin
      mem_addr <= host_addr;
      dq_out   <= host_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rd_data <= '0;
    else if (capture) rd_data <= dq_in;
  end
endmodule

// File: rtl/asram_port_ctrl.sv
module asram_port_ctrl
  import asram_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 8,
  parameter int T_AA_CYC  = 4,
  parameter int T_ACE_CYC = 4,
  parameter int T_AOE_CYC = 3,
  parameter int T_WP_CYC  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              req_wr,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              ready,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_ce_n,
  output logic              sram_we_n,
  output logic              sram_oe_n,
  output logic [DATA_W-1:0] sram_dq_out,
  output logic              sram_dq_oe,
  input  logic [DATA_W-1:0] sram_dq_in
);
  localparam int RD_WAIT = max3(T_AA_CYC, T_ACE_CYC, T_AOE_CYC);
  localparam int MAX_W   = (RD_WAIT > T_WP_CYC) ? RD_WAIT : T_WP_CYC;
  localparam int CW      = $clog2(MAX_W + 1);

  asram_state_e  state_q, state_d;
  logic          accept, cnt_load, cnt_done;
  logic [CW-1:0] cnt_val;

  asram_fsm #(.CW(CW), .RD_WAIT(RD_WAIT), .WR_PULSE(T_WP_CYC)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (req),
    .req_wr   (req_wr),
    .cnt_done (cnt_done),
    .state_q  (state_q),
    .state_d  (state_d),
    .accept   (accept),
    .ready    (ready),
    .cnt_load (cnt_load),
    .cnt_val  (cnt_val)
  );

  asram_wait_cnt #(.CW(CW)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cnt_load),
    .load_val (cnt_val),
    .done     (cnt_done)
  );

  asram_pins #(.AW(ADDR_W), .DW(DATA_W)) u_pins (
    .clk        (clk),
    .rst_n      (rst_n),
    .state_q    (state_q),
    .state_d    (state_d),
    .accept     (accept),
    .cnt_done   (cnt_done),
    .host_addr  (req_addr),
    .host_wdata (req_wdata),
    .dq_in      (sram_dq_in),
    .mem_addr   (sram_addr),
    .dq_out     (sram_dq_out),
    .dq_oe      (sram_dq_oe),
    .ce_n       (sram_ce_n),
    .we_n       (sram_we_n),
    .oe_n       (sram_oe_n),
    .rd_data    (rd_data),
    .rd_valid   (rd_valid)
  );
endmodule

// File: rtl/asram_port_ctrl_chk.sv
module asram_port_ctrl_chk #(
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 8,
  parameter int T_WP_CYC = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ready,
  input logic              rd_valid,
  input logic [ADDR_W-1:0] sram_addr,
  input logic              sram_ce_n,
  input logic              sram_we_n,
  input logic              sram_oe_n,
  input logic [DATA_W-1:0] sram_dq_out,
  input logic              sram_dq_oe
);
  localparam int PW = $clog2(T_WP_CYC + 2);

  logic [PW-1:0] we_low_cnt;

  // Counts consecutive sampled cycles with the write strobe low.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        we_low_cnt <= '0;
    else if (sram_we_n)                we_low_cnt <= '0;
    else if (we_low_cnt != {PW{1'b1}}) we_low_cnt <= we_low_cnt + 1'b1;
  end

  a_r2_busy_while_selected: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_ce_n |-> !ready);

  a_r3_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_ce_n && !$past(sram_ce_n)) |-> $stable(sram_addr));

  a_r4_strobes_fall_together: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sram_we_n) |-> $fell(sram_ce_n));

  a_r4_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_we_n) |-> (we_low_cnt == PW'(T_WP_CYC)));

  a_r5_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_we_n) |-> (sram_dq_oe && $stable(sram_dq_out)));

  a_r5_no_bus_fight: assert property (@(posedge clk) disable iff (!rst_n)
    sram_dq_oe |-> sram_oe_n);

  a_r6_read_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_oe_n |-> (sram_we_n && !sram_ce_n));

  a_r7_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);
endmodule

bind asram_port_ctrl asram_port_ctrl_chk #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .T_WP_CYC (T_WP_CYC)
) u_chk (.*);

// File: tb/asram_port_ctrl_tb.sv
module asram_port_ctrl_tb;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int AW  = 12;
  localparam int DW  = 8;
  localparam int TAA = 4;
  localparam int TCE = 4;
  localparam int TOE = 3;
  localparam int WP  = 3;
  localparam int RDW = (TAA > TCE) ? ((TAA > TOE) ? TAA : TOE) : ((TCE > TOE) ? TCE : TOE);

  typedef struct {
    bit          wr;
    logic [11:0] a;
    logic [7:0]  d;
    int          gap;
  } op_t;

  logic          clk, rst_n, req, req_wr;
  logic [AW-1:0] req_addr, sram_addr;
  logic [DW-1:0] req_wdata, rd_data, sram_dq_out, sram_dq_in;
  logic          ready, rd_valid, sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe;

  asram_port_ctrl #(
    .ADDR_W(AW), .DATA_W(DW), .T_AA_CYC(TAA), .T_ACE_CYC(TCE),
    .T_AOE_CYC(TOE), .T_WP_CYC(WP)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr),
    .req_addr(req_addr), .req_wdata(req_wdata), .ready(ready),
    .rd_valid(rd_valid), .rd_data(rd_data), .sram_addr(sram_addr),
    .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n),
    .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe), .sram_dq_in(sram_dq_in)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Memory model and bench shadow, both sparse.
  logic [7:0] mem[int];
  logic [7:0] shadow[int];

  function automatic logic [7:0] seed_b(input int a);
    return 8'(a) ^ {4'(a >> 8), 4'h5};
  endfunction

  function automatic logic [7:0] mem_get(input int a);
    return mem.exists(a) ? mem[a] : seed_b(a);
  endfunction

  function automatic logic [7:0] sh_get(input int a);
    return shadow.exists(a) ? shadow[a] : seed_b(a);
  endfunction

  logic [15:0] lfsr = 16'hACE1;
  function automatic logic [15:0] step(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  logic [7:0] dq_drv;
  assign sram_dq_in = dq_drv;

  op_t ops[$];
  op_t acc;
  int  idx, gap_cnt, busy, tail;
  bit  acc_pending, kind_wr, exp_valid, rd_act, ovl, prev_ovl, prev_ce_n, finished;
  logic [11:0] exp_addr, prev_addr, w_addr;
  logic [7:0]  exp_wd, exp_rd, w_data;
  int  w_cnt, rd_cnt, hi_run;
  bit  e_ce_n, e_we_n, e_oe_n, e_dq_oe, e_ready;

  initial begin
    // Directed: extremes, back-to-back, read-after-write.
    ops.push_back('{1'b1, 12'h000, 8'h3C, 0});
    ops.push_back('{1'b1, 12'hFFF, 8'hC3, 0});
    ops.push_back('{1'b0, 12'h000, 8'h00, 0});
    ops.push_back('{1'b0, 12'hFFF, 8'h00, 2});
    ops.push_back('{1'b0, 12'h123, 8'h00, 0});
    ops.push_back('{1'b1, 12'h123, 8'h7E, 0});
    ops.push_back('{1'b0, 12'h123, 8'h00, 0});
    ops.push_back('{1'b1, 12'h123, 8'h81, 1});
    ops.push_back('{1'b0, 12'h123, 8'h00, 3});
    ops.push_back('{1'b1, 12'h800, 8'hFF, 1});
    ops.push_back('{1'b0, 12'h800, 8'h00, 0});
    for (int i = 0; i < 48; i++) begin
      op_t o;
      lfsr  = step(lfsr);
      o.wr  = lfsr[0];
      o.a   = {lfsr[15], 7'h2A, lfsr[3:1], lfsr[5]};
      o.d   = lfsr[13:6];
      o.gap = int'(lfsr[9:8]) % 3;
      ops.push_back(o);
    end

    rst_n = 1'b0; req = 1'b0; req_wr = 1'b0; req_addr = '0; req_wdata = '0;
    dq_drv = 8'h5A;
    idx = 0; gap_cnt = 0; busy = 0; tail = 0; acc_pending = 0; kind_wr = 0;
    prev_ovl = 0; prev_ce_n = 1; prev_addr = '0; w_cnt = 0; rd_cnt = 0; hi_run = 2;
    w_addr = '0; w_data = '0; exp_addr = '0; exp_wd = '0; exp_rd = '0; finished = 0;

    repeat (3) @(negedge clk);
    chk(ready == 1'b1,      "R1", "ready in reset", int'(ready), 1);
    chk(sram_ce_n == 1'b1,  "R1", "ce_n in reset", int'(sram_ce_n), 1);
    chk(sram_we_n == 1'b1,  "R1", "we_n in reset", int'(sram_we_n), 1);
    chk(sram_oe_n == 1'b1,  "R1", "oe_n in reset", int'(sram_oe_n), 1);
    chk(sram_dq_oe == 1'b0, "R1", "dq_oe in reset", int'(sram_dq_oe), 0);
    chk(rd_valid == 1'b0,   "R1", "rd_valid in reset", int'(rd_valid), 0);
    rst_n = 1'b1;

    for (int cyc = 0; cyc < 20000 && !finished; cyc++) begin
      @(negedge clk);

      // Reference: advance by the edge just passed.
      exp_valid = 1'b0;
      if (busy > 0) begin
        busy--;
        if (busy == 0 && !kind_wr) exp_valid = 1'b1;
      end
      if (acc_pending) begin
        kind_wr  = acc.wr;
        exp_addr = acc.a;
        exp_wd   = acc.d;
        busy     = acc.wr ? WP + 2 : RDW + 1;
        if (acc.wr) shadow[int'(acc.a)] = acc.d;
        else        exp_rd = sh_get(int'(acc.a));
      end
      e_ready = (busy == 0);
      e_oe_n  = !(!kind_wr && busy >= 1 && busy <= RDW);
      e_we_n  = !(kind_wr && busy >= 2 && busy <= WP + 1);
      e_ce_n  = e_oe_n && e_we_n;
      e_dq_oe = kind_wr && busy >= 1 && busy <= WP + 1;

      // Per-cycle comparison against the reference.
      chk(ready == e_ready, "R2", "ready", int'(ready), int'(e_ready));
      chk(sram_ce_n == e_ce_n, kind_wr ? "R4" : "R6", "ce_n", int'(sram_ce_n), int'(e_ce_n));
      chk(sram_we_n == e_we_n, "R4", "we_n", int'(sram_we_n), int'(e_we_n));
      chk(sram_oe_n == e_oe_n, kind_wr ? "R5" : "R6", "oe_n", int'(sram_oe_n), int'(e_oe_n));
      chk(sram_dq_oe == e_dq_oe, "R5", "dq_oe", int'(sram_dq_oe), int'(e_dq_oe));
      chk(rd_valid == exp_valid, "R7", "rd_valid", int'(rd_valid), int'(exp_valid));
      if (exp_valid)
        chk(rd_data == exp_rd, "R10", "rd_data", int'(rd_data), int'(exp_rd));
      if (!sram_ce_n)
        chk(sram_addr == exp_addr, "R9", "sram_addr", int'(sram_addr), int'(exp_addr));
      if (sram_dq_oe)
        chk(sram_dq_out == exp_wd, "R9", "dq_out", int'(sram_dq_out), int'(exp_wd));

      // Memory model: timing rules and storage.
      if (!sram_ce_n && !prev_ce_n)
        chk(sram_addr == prev_addr, "R3", "addr moved under ce", int'(sram_addr), int'(prev_addr));
      if (!sram_ce_n && prev_ce_n) begin
        chk(hi_run >= 2, "R8", "deselect gap", hi_run, 2);
        chk(sram_addr == prev_addr, "R3", "addr setup", int'(sram_addr), int'(prev_addr));
      end
      hi_run = sram_ce_n ? hi_run + 1 : 0;

      ovl = !sram_ce_n && !sram_we_n;
      if (ovl && !prev_ovl) begin
        chk(prev_ce_n == 1'b1, "R4", "ce before we", int'(prev_ce_n), 1);
        w_addr = sram_addr; w_data = sram_dq_out; w_cnt = 1;
      end else if (ovl) begin
        w_cnt++;
        chk(sram_dq_out == w_data, "R5", "data setup", int'(sram_dq_out), int'(w_data));
      end
      if (ovl)
        chk(sram_oe_n == 1'b1, "R5", "oe during write", int'(sram_oe_n), 1);
      if (!ovl && prev_ovl) begin
        chk(w_cnt == WP, "R4", "write pulse", w_cnt, WP);
        chk(sram_dq_oe && sram_dq_out == w_data, "R5", "data hold",
            int'(sram_dq_out), int'(w_data));
        mem[int'(w_addr)] = w_data;
      end
      prev_ovl = ovl;

      rd_act = !sram_ce_n && !sram_oe_n && sram_we_n;
      if (rd_act && sram_dq_oe)
        chk(1'b0, "R5", "bus fight", 1, 0);
      rd_cnt = rd_act ? rd_cnt + 1 : 0;
      if (rd_act) dq_drv = (rd_cnt >= RDW) ? mem_get(int'(sram_addr)) : ~mem_get(int'(sram_addr));
      else        dq_drv = 8'h5A;
      prev_ce_n = sram_ce_n;
      prev_addr = sram_addr;

      // Host stimulus.
      lfsr = step(lfsr);
      if (gap_cnt > 0) begin
        gap_cnt--;
        req = 1'b0; req_wr = lfsr[0]; req_addr = lfsr[11:0]; req_wdata = lfsr[15:8];
      end else if (idx < ops.size()) begin
        req = 1'b1; req_wr = ops[idx].wr; req_addr = ops[idx].a; req_wdata = ops[idx].d;
      end else begin
        req = 1'b0; req_addr = lfsr[11:0]; req_wdata = lfsr[15:8];
      end
      acc_pending = req && ready;
      if (acc_pending) begin
        acc = ops[idx];
        idx++;
        gap_cnt = acc.gap;
      end

      if (idx >= ops.size() && busy == 0 && !acc_pending) tail++;
      if (tail > 4) finished = 1'b1;
    end

    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=%0d expected=%0d ops done", idx, ops.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule